// File: doc/BRIEF.md
# Timer Compare-Value Access Router

This block is a purely combinational decoder. It sits between the system-register access path and the timer compare-value storage. It receives one access per cycle, aimed at a timer compare value, and settles its outcome. The outcome is one of four: the access is undefined, it traps to a higher privilege level, it is redirected to a fixed slot in memory, or it reaches one of three storage copies. The three copies are the guest copy, the non-secure hypervisor copy and the secure hypervisor copy.

An access arrives under one of two names, the guest name or the hypervisor name. It carries the current privilege level (0 to 3) and a read/write direction. Around it sit control bits: level-2 enable, the two host-mode bits, the three nested-virtualisation bits, the non-secure state, the presence of the secure level-2 feature, and four timer access-enable bits. The outputs drive the storage select, the exception-entry logic and the memory-redirect path. The storage registers and exception entry sit outside this block.

Top module: `timer_cmp_access_router`

## Requirements
- R1: While `acc_valid` is 0, the outputs `res_undef`, `res_trap`, `res_mem`, `res_reg` and `res_write` are all 0.
- R2: While `acc_valid` is 1, exactly one of `res_undef`, `res_trap`, `res_mem` and `res_reg` is 1.
- R3: During a trap, `trap_class` is 0x18 and `trap_level` is 1 or 2. With no trap, both are 0. `reg_sel` is 0 unless `res_reg` is set. `mem_offset` is 0 unless `res_mem` is set.
- R4: Under the hypervisor name (`acc_hyp_name`=1), each level gives a fixed outcome. Level 0 is undefined. At level 1 the access traps to level 2 when `l2_enabled` and `nest_ctrl[0]` are both 1, and is undefined otherwise. Levels 2 and 3 reach the non-secure hypervisor copy (`reg_sel`=1).
- R5: Under the guest name at level 0, the first check is this. Unless `l2_enabled`, `host_os_en` and `host_trap_gen` are all 1, a clear `kern_el0_tmr_en` traps the access. The target is level 2 when `l2_enabled` and `host_trap_gen` are both 1, and level 1 otherwise.
- R6: Under the guest name at level 0, three further checks follow in this order, and each traps to level 2. First, `host_os_en`=0 with `hyp_l1_cnt_en`=0. Second, {`host_os_en`,`host_trap_gen`}=10 with `hyp_l1_tmr_en`=0. Third, {`host_os_en`,`host_trap_gen`}=11 with `hyp_el0_tmr_en`=0.
- R7: Under the guest name at level 0 with {`host_os_en`,`host_trap_gen`}=11 and no trap, the access goes to a copy chosen by security state. With `nonsecure`=0 and `sec_l2_avail`=1 it reaches the secure hypervisor copy (`reg_sel`=2). With `nonsecure`=1 it reaches the non-secure hypervisor copy (`reg_sel`=1). In every other case it reaches the guest copy (`reg_sel`=0).
- R8: Under the guest name at level 1, the access traps to level 2 in two cases: `host_os_en`=0 with `hyp_l1_cnt_en`=0, or `host_os_en`=1 with `hyp_l1_tmr_en`=0.
- R9: Under the guest name at level 1 with no trap, `nest_ctrl`=3'b111 redirects the access to memory with `mem_offset`=0x178. Otherwise it reaches the guest copy.
- R10: Under the guest name at level 2 with `host_os_en`=1, the copy follows the R7 selection. With `host_os_en`=0 it is the guest copy.
- R11: Under the guest name at level 3, the access always reaches the guest copy.
- R12: At levels 0 and 1, while `l2_enabled`=0, no condition on a level-2 control bit applies. So there is no trap to level 2, no memory redirect and no hypervisor copy.
- R13: Reads and writes route identically. `res_write` equals `acc_valid` AND `acc_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_valid | input | 1 | An access is presented |
| acc_level | input | 2 | Current privilege level, 0 to 3 |
| acc_hyp_name | input | 1 | 1 = hypervisor name, 0 = guest name |
| acc_write | input | 1 | 1 = write, 0 = read |
| l2_enabled | input | 1 | Level 2 is enabled |
| host_os_en | input | 1 | Host-mode bit: hypervisor hosts an OS |
| host_trap_gen | input | 1 | Host-mode bit: general traps go to level 2 |
| nest_ctrl | input | 3 | Nested-virtualisation bits, bit 0 the basic one |
| nonsecure | input | 1 | 1 = non-secure state |
| sec_l2_avail | input | 1 | Secure level-2 feature present |
| kern_el0_tmr_en | input | 1 | Kernel grant of level-0 timer access |
| hyp_l1_cnt_en | input | 1 | Hypervisor grant, non-host mode |
| hyp_l1_tmr_en | input | 1 | Hypervisor grant of level-1 timer access |
| hyp_el0_tmr_en | input | 1 | Hypervisor grant of level-0 access in host mode |
| res_undef | output | 1 | Access is undefined |
| res_trap | output | 1 | Access traps |
| res_mem | output | 1 | Access redirected to memory |
| res_reg | output | 1 | Access reaches a storage copy |
| trap_level | output | 2 | Trap target level |
| trap_class | output | 6 | Trap class code |
| reg_sel | output | 2 | 0 guest, 1 non-secure hyp, 2 secure hyp copy |
| mem_offset | output | 12 | Memory slot offset |
| res_write | output | 1 | Direction of a valid access |

## Verification
The assertions check the structural properties on every evaluation. These are the one-hot outcome, the gating by `acc_valid`, the trap class and zeroed side outputs, the fixed answers of the hypervisor name and of level 3, memory redirects only at level 1, and the absence of any level-2 effect while level 2 is disabled. The strict priority order among the level-0 checks shows only in the bench's scenarios. So does the security-driven copy choice, since only a scenario can put two conditions true at once and see which one wins. Overlapping cases such as a cleared kernel grant together with cleared hypervisor grants are covered by the directed scenarios and by the random mix.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

  localparam int LVL_W        = 2;
  localparam int NEST_W       = 3;
  localparam int NUM_OUTCOMES = 4;

  typedef enum logic [1:0] {
    OC_UNDEF = 2'd0,
    OC_TRAP  = 2'd1,
    OC_MEM   = 2'd2,
    OC_REG   = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    ST_GUEST   = 2'd0,
    ST_HYP_NS  = 2'd1,
    ST_HYP_SEC = 2'd2
  } store_e;

  typedef struct packed {
    logic              l2_on;
    logic              host_e;
    logic              host_g;
    logic [NEST_W-1:0] nest;
    logic              ns;
    logic              sec_avail;
    logic              k_el0;
    logic              h_l1_cnt;
    logic              h_l1_tmr;
    logic              h_el0;
  } ctrl_t;

  typedef struct packed {
    outcome_e         kind;
    logic [LVL_W-1:0] tlvl;
    store_e           sel;
  } route_t;

  function automatic route_t mk_route(outcome_e k, logic [LVL_W-1:0] t, store_e s);
    route_t r;
    r.kind = k;
    r.tlvl = t;
    r.sel  = s;
    return r;
  endfunction

  // Copy chosen by security state when the host-mode path applies.
  function automatic store_e host_copy(ctrl_t c);
    if (!c.ns && c.sec_avail) return ST_HYP_SEC;
    else if (c.ns)            return ST_HYP_NS;
    else                      return ST_GUEST;
  endfunction

  function automatic route_t route_hyp(logic [LVL_W-1:0] lvl, ctrl_t c);
    case (lvl)
      2'd0:    return mk_route(OC_UNDEF, 2'd0, ST_GUEST);
      2'd1:    return (c.l2_on && c.nest[0]) ? mk_route(OC_TRAP, 2'd2, ST_GUEST)
                                             : mk_route(OC_UNDEF, 2'd0, ST_GUEST);
      default: return mk_route(OC_REG, 2'd0, ST_HYP_NS);
    endcase
  endfunction

  function automatic route_t route_guest(logic [LVL_W-1:0] lvl, ctrl_t c);
    logic hm11;
    hm11 = c.l2_on && c.host_e && c.host_g;
    case (lvl)
      2'd0: begin
        if (!hm11 && !c.k_el0)
          return mk_route(OC_TRAP, (c.l2_on && c.host_g) ? 2'd2 : 2'd1, ST_GUEST);
        else if (c.l2_on && !c.host_e && !c.h_l1_cnt)
          return mk_route(OC_TRAP, 2'd2, ST_GUEST);
        else if (c.l2_on && c.host_e && !c.host_g && !c.h_l1_tmr)
          return mk_route(OC_TRAP, 2'd2, ST_GUEST);
        else if (hm11 && !c.h_el0)
          return mk_route(OC_TRAP, 2'd2, ST_GUEST);
        else if (hm11)
          return mk_route(OC_REG, 2'd0, host_copy(c));
        else
          return mk_route(OC_REG, 2'd0, ST_GUEST);
      end
      2'd1: begin
        if (c.l2_on && !c.host_e && !c.h_l1_cnt)
          return mk_route(OC_TRAP, 2'd2, ST_GUEST);
        else if (c.l2_on && c.host_e && !c.h_l1_tmr)
          return mk_route(OC_TRAP, 2'd2, ST_GUEST);
        else if (c.l2_on && (&c.nest))
          return mk_route(OC_MEM, 2'd0, ST_GUEST);
        else
          return mk_route(OC_REG, 2'd0, ST_GUEST);
      end
      2'd2: return mk_route(OC_REG, 2'd0, c.host_e ? host_copy(c) : ST_GUEST);
      default: return mk_route(OC_REG, 2'd0, ST_GUEST);
    endcase
  endfunction

endpackage

// File: rtl/tcr_hyp_decode.sv
module tcr_hyp_decode
  import tcr_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  ctrl_t            ctrl,
  output route_t           route
);
  always_comb route = route_hyp(level, ctrl);
endmodule

// File: rtl/tcr_guest_decode.sv
module tcr_guest_decode
  import tcr_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  ctrl_t            ctrl,
  output route_t           route
);
  always_comb route = route_guest(level, ctrl);
endmodule

// File: rtl/tcr_outcome_drive.sv
module tcr_outcome_drive
  import tcr_pkg::*;
#(
  parameter int                        TRAP_CLASS_W    = 6,
  parameter logic [TRAP_CLASS_W-1:0]   TRAP_CLASS_CODE = 'h18,
  parameter int                        MEM_OFF_W       = 12,
  parameter logic [MEM_OFF_W-1:0]      MEM_SLOT_OFFSET = 'h178
) (
  input  logic                    valid,
  input  logic                    write,
  input  route_t                  route,
  output logic [NUM_OUTCOMES-1:0] flags,
  output logic [LVL_W-1:0]        trap_level,
  output logic [TRAP_CLASS_W-1:0] trap_class,
  output logic [1:0]              reg_sel,
  output logic [MEM_OFF_W-1:0]    mem_offset,
  output logic                    dir_write
);
  for (genvar k = 0; k < NUM_OUTCOMES; k++) begin : g_flag
    assign flags[k] = valid && (route.kind == outcome_e'(k));
  end

  always_comb begin
    trap_level = flags[OC_TRAP] ? route.tlvl : '0;
    trap_class = flags[OC_TRAP] ? TRAP_CLASS_CODE : '0;
    reg_sel    = flags[OC_REG]  ? route.sel : ST_GUEST;
    mem_offset = flags[OC_MEM]  ? MEM_SLOT_OFFSET : '0;
    dir_write  = valid && write;
  end
endmodule

// File: rtl/timer_cmp_access_router.sv
module timer_cmp_access_router
  import tcr_pkg::*;
#(
  parameter int                        TRAP_CLASS_W    = 6,
  parameter logic [TRAP_CLASS_W-1:0]   TRAP_CLASS_CODE = 'h18,
  parameter int                        MEM_OFF_W       = 12,
  parameter logic [MEM_OFF_W-1:0]      MEM_SLOT_OFFSET = 'h178
) (
  input  logic                    acc_valid,
  input  logic [1:0]              acc_level,
  input  logic                    acc_hyp_name,
  input  logic                    acc_write,
  input  logic                    l2_enabled,
  input  logic                    host_os_en,
  input  logic                    host_trap_gen,
  input  logic [2:0]              nest_ctrl,
  input  logic                    nonsecure,
  input  logic                    sec_l2_avail,
  input  logic                    kern_el0_tmr_en,
  input  logic                    hyp_l1_cnt_en,
  input  logic                    hyp_l1_tmr_en,
  input  logic                    hyp_el0_tmr_en,
  output logic                    res_undef,
  output logic                    res_trap,
  output logic                    res_mem,
  output logic                    res_reg,
  output logic [1:0]              trap_level,
  output logic [TRAP_CLASS_W-1:0] trap_class,
  output logic [1:0]              reg_sel,
  output logic [MEM_OFF_W-1:0]    mem_offset,
  output logic                    res_write
);
  ctrl_t                   ctrl;
  route_t                  hyp_route;
  route_t                  guest_route;
  route_t                  sel_route;
  logic [NUM_OUTCOMES-1:0] outcome_flags;

  always_comb begin
    ctrl.l2_on     = l2_enabled;
    ctrl.host_e    = host_os_en;
    ctrl.host_g    = host_trap_gen;
    ctrl.nest      = nest_ctrl;
    ctrl.ns        = nonsecure;
    ctrl.sec_avail = sec_l2_avail;
    ctrl.k_el0     = kern_el0_tmr_en;
    ctrl.h_l1_cnt  = hyp_l1_cnt_en;
    ctrl.h_l1_tmr  = hyp_l1_tmr_en;
    ctrl.h_el0     = hyp_el0_tmr_en;
  end

  tcr_hyp_decode u_hyp (
    .level (acc_level),
    .ctrl  (ctrl),
    .route (hyp_route)
  );

  tcr_guest_decode u_guest (
    .level (acc_level),
    .ctrl  (ctrl),
    .route (guest_route)
  );

  assign sel_route = acc_hyp_name ? hyp_route : guest_route;

  tcr_outcome_drive #(
    .TRAP_CLASS_W    (TRAP_CLASS_W),
    .TRAP_CLASS_CODE (TRAP_CLASS_CODE),
    .MEM_OFF_W       (MEM_OFF_W),
    .MEM_SLOT_OFFSET (MEM_SLOT_OFFSET)
  ) u_drive (
    .valid      (acc_valid),
    .write      (acc_write),
    .route      (sel_route),
    .flags      (outcome_flags),
    .trap_level (trap_level),
    .trap_class (trap_class),
    .reg_sel    (reg_sel),
    .mem_offset (mem_offset),
    .dir_write  (res_write)
  );

  assign res_undef = outcome_flags[OC_UNDEF];
  assign res_trap  = outcome_flags[OC_TRAP];
  assign res_mem   = outcome_flags[OC_MEM];
  assign res_reg   = outcome_flags[OC_REG];
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
  parameter int                        TRAP_CLASS_W    = 6,
  parameter logic [TRAP_CLASS_W-1:0]   TRAP_CLASS_CODE = 'h18,
  parameter int                        MEM_OFF_W       = 12,
  parameter logic [MEM_OFF_W-1:0]      MEM_SLOT_OFFSET = 'h178
) (
  input logic                    acc_valid,
  input logic [1:0]              acc_level,
  input logic                    acc_hyp_name,
  input logic                    acc_write,
  input logic                    l2_enabled,
  input logic [2:0]              nest_ctrl,
  input logic                    nonsecure,
  input logic                    sec_l2_avail,
  input logic                    res_undef,
  input logic                    res_trap,
  input logic                    res_mem,
  input logic                    res_reg,
  input logic [1:0]              trap_level,
  input logic [TRAP_CLASS_W-1:0] trap_class,
  input logic [1:0]              reg_sel,
  input logic [MEM_OFF_W-1:0]    mem_offset,
  input logic                    res_write
);
  logic [3:0] fl;
  assign fl = {res_undef, res_trap, res_mem, res_reg};

  always_comb begin
    assert_idle_quiet_R1: assert (acc_valid || (fl == 4'b0 && !res_write))
      else $error("outcome asserted without a valid access");
    assert_one_outcome_R2: assert (!acc_valid || $countones(fl) == 1)
      else $error("outcome flags not one-hot");
    assert_trap_fields_R3: assert (res_trap ? (trap_class == TRAP_CLASS_CODE &&
                                               (trap_level == 2'd1 || trap_level == 2'd2))
                                            : (trap_class == '0 && trap_level == 2'd0))
      else $error("trap side outputs wrong");
    assert_side_zero_R3: assert ((res_reg || reg_sel == 2'd0) && (res_mem || mem_offset == '0))
      else $error("unused side output not zero");
    assert_hyp_low_undef_R4: assert (!(acc_valid && acc_hyp_name && acc_level == 2'd0) || res_undef)
      else $error("hypervisor name at level 0 not undefined");
    assert_hyp_high_ns_R4: assert (!(acc_valid && acc_hyp_name && acc_level[1]) ||
                                   (res_reg && reg_sel == 2'd1))
      else $error("hypervisor name at level 2/3 not on non-secure copy");
    assert_lvl1_trap_src_R5: assert (!(res_trap && trap_level == 2'd1) ||
                                     (acc_level == 2'd0 && !acc_hyp_name))
      else $error("trap to level 1 from wrong source");
    assert_sec_copy_R7: assert (!(res_reg && reg_sel == 2'd2) || (!nonsecure && sec_l2_avail))
      else $error("secure copy chosen outside secure state");
    assert_mem_slot_R9: assert (!res_mem || (mem_offset == MEM_SLOT_OFFSET && acc_level == 2'd1 &&
                                             !acc_hyp_name && nest_ctrl == 3'b111 && l2_enabled))
      else $error("memory redirect under wrong conditions");
    assert_top_guest_R11: assert (!(acc_valid && !acc_hyp_name && acc_level == 2'd3) ||
                                  (res_reg && reg_sel == 2'd0))
      else $error("level 3 guest name not on guest copy");
    assert_l2_off_R12: assert (!(acc_valid && !l2_enabled && !acc_level[1]) ||
                               (!(res_trap && trap_level == 2'd2) && !res_mem &&
                                !(res_reg && reg_sel != 2'd0)))
      else $error("level-2 control applied while level 2 disabled");
    assert_direction_R13: assert (res_write == (acc_valid && acc_write))
      else $error("direction output wrong");
  end
endmodule

bind timer_cmp_access_router tcr_checker #(
  .TRAP_CLASS_W    (TRAP_CLASS_W),
  .TRAP_CLASS_CODE (TRAP_CLASS_CODE),
  .MEM_OFF_W       (MEM_OFF_W),
  .MEM_SLOT_OFFSET (MEM_SLOT_OFFSET)
) u_tcr_checker (
  .acc_valid    (acc_valid),
  .acc_level    (acc_level),
  .acc_hyp_name (acc_hyp_name),
  .acc_write    (acc_write),
  .l2_enabled   (l2_enabled),
  .nest_ctrl    (nest_ctrl),
  .nonsecure    (nonsecure),
  .sec_l2_avail (sec_l2_avail),
  .res_undef    (res_undef),
  .res_trap     (res_trap),
  .res_mem      (res_mem),
  .res_reg      (res_reg),
  .trap_level   (trap_level),
  .trap_class   (trap_class),
  .reg_sel      (reg_sel),
  .mem_offset   (mem_offset),
  .res_write    (res_write)
);

// File: tb/test_timer_cmp_access_router.sv
module test_timer_cmp_access_router;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        acc_valid, acc_hyp_name, acc_write, l2_enabled, host_os_en, host_trap_gen;
  logic [1:0]  acc_level;
  logic [2:0]  nest_ctrl;
  logic        nonsecure, sec_l2_avail, kern_el0_tmr_en, hyp_l1_cnt_en, hyp_l1_tmr_en, hyp_el0_tmr_en;
  logic        res_undef, res_trap, res_mem, res_reg, res_write;
  logic [1:0]  trap_level, reg_sel;
  logic [5:0]  trap_class;
  logic [11:0] mem_offset;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  timer_cmp_access_router i_timer_cmp_access_router (.*);

  // expected vector: {undef, trap, mem, reg, tlvl[1:0], sel[1:0], class[5:0], offset[11:0], write}
  function automatic logic [26:0] expect_vec();
    logic u, t, m, r;
    logic [1:0] tl, sl, hs;
    logic hm;
    u = 0; t = 0; m = 0; r = 0; tl = 0; sl = 0;
    hs = nonsecure ? 2'd1 : (sec_l2_avail ? 2'd2 : 2'd0);
    hm = l2_enabled & host_os_en & host_trap_gen;
    if (acc_valid) begin
      if (acc_hyp_name) begin
        if (acc_level >= 2) begin r = 1; sl = 1; end
        else if (acc_level == 1 && l2_enabled && nest_ctrl[0]) begin t = 1; tl = 2; end
        else u = 1;
      end else if (acc_level == 3) r = 1;
      else if (acc_level == 2) begin r = 1; sl = host_os_en ? hs : 2'd0; end
      else if (acc_level == 1) begin
        if (l2_enabled && (host_os_en ? !hyp_l1_tmr_en : !hyp_l1_cnt_en)) begin t = 1; tl = 2; end
        else if (l2_enabled && nest_ctrl == 3'b111) m = 1;
        else r = 1;
      end else begin
        if (!hm && !kern_el0_tmr_en) begin t = 1; tl = (l2_enabled && host_trap_gen) ? 2'd2 : 2'd1; end
        else if (l2_enabled && ((!host_os_en && !hyp_l1_cnt_en) ||
                                (host_os_en && !host_trap_gen && !hyp_l1_tmr_en) ||
                                (hm && !hyp_el0_tmr_en))) begin t = 1; tl = 2; end
        else begin r = 1; sl = hm ? hs : 2'd0; end
      end
    end
    return {u, t, m, r, tl, sl, (t ? 6'h18 : 6'h0), (m ? 12'h178 : 12'h0), acc_valid & acc_write};
  endfunction

  function automatic string tag_of();
    if (!acc_valid) return "R1";
    if (acc_hyp_name) return "R4";
    case (acc_level)
      2'd3: return "R11";
      2'd2: return "R10";
      2'd1: return (nest_ctrl == 3'b111) ? "R9" : "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic put(input logic v, input logic [1:0] lv, input logic hy, input logic w,
                     input logic en, input logic e, input logic g, input logic [2:0] nv,
                     input logic ns, input logic sa, input logic k, input logic pc,
                     input logic pt, input logic h0);
    @(posedge clk); #1;
    acc_valid = v; acc_level = lv; acc_hyp_name = hy; acc_write = w;
    l2_enabled = en; host_os_en = e; host_trap_gen = g; nest_ctrl = nv;
    nonsecure = ns; sec_l2_avail = sa; kern_el0_tmr_en = k;
    hyp_l1_cnt_en = pc; hyp_l1_tmr_en = pt; hyp_el0_tmr_en = h0;
  endtask

  task automatic check(input string req);
    logic [26:0] act, exp_v;
    @(negedge clk);
    exp_v = expect_vec();
    act = {res_undef, res_trap, res_mem, res_reg, trap_level, reg_sel, trap_class, mem_offset, res_write};
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // reset phase: no access presented
    put(0,0,0,1, 1,1,1,3'b111, 1,1,0,0,0,0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check("R1");
    // R4 hypervisor name
    put(1,0,1,0, 1,1,1,3'b111, 1,1,1,1,1,1); check("R4");
    put(1,1,1,1, 1,0,0,3'b001, 1,1,1,1,1,1); check("R4");
    put(1,1,1,0, 0,0,0,3'b001, 1,1,1,1,1,1); check("R4");
    put(1,3,1,1, 0,0,0,3'b000, 0,1,1,1,1,1); check("R4");
    // R5 kernel grant first
    put(1,0,0,0, 1,0,1,3'b000, 1,0,0,0,0,0); check("R5");
    put(1,0,0,0, 0,1,1,3'b000, 1,0,0,1,1,1); check("R5");
    put(1,0,0,0, 1,1,1,3'b000, 1,0,0,1,1,0); check("R5");
    // R6 ordered level-2 checks
    put(1,0,0,1, 1,0,0,3'b000, 1,0,1,0,0,0); check("R6");
    put(1,0,0,0, 1,1,0,3'b000, 1,0,1,0,0,1); check("R6");
    put(1,0,0,0, 1,1,1,3'b000, 1,1,1,0,0,0); check("R6");
    // R7 host-mode copy selection
    put(1,0,0,0, 1,1,1,3'b000, 0,1,0,0,0,1); check("R7");
    put(1,0,0,0, 1,1,1,3'b000, 1,1,0,0,0,1); check("R7");
    put(1,0,0,0, 1,1,1,3'b000, 0,0,0,0,0,1); check("R7");
    // R8 / R9 level 1
    put(1,1,0,0, 1,0,0,3'b111, 1,1,1,0,1,1); check("R8");
    put(1,1,0,1, 1,1,0,3'b111, 1,1,1,1,0,1); check("R8");
    put(1,1,0,1, 1,1,0,3'b111, 1,1,1,1,1,1); check("R9");
    put(1,1,0,0, 1,1,0,3'b011, 1,1,1,1,1,1); check("R9");
    // R10 / R11
    put(1,2,0,0, 0,1,0,3'b000, 0,1,0,0,0,0); check("R10");
    put(1,2,0,0, 1,0,1,3'b000, 1,1,0,0,0,0); check("R10");
    put(1,3,0,1, 1,1,1,3'b111, 0,1,0,0,0,0); check("R11");
    // R12 level 2 disabled
    put(1,1,0,0, 0,1,1,3'b111, 1,1,0,0,0,0); check("R12");
    put(1,0,0,0, 0,1,1,3'b000, 1,1,1,0,0,0); check("R12");
    // R13 read/write identical, R3 fields, R2 one-hot via random mix
    put(1,1,0,0, 1,1,1,3'b111, 1,1,1,1,1,1); check("R13");
    put(1,1,0,1, 1,1,1,3'b111, 1,1,1,1,1,1); check("R13");
    put(0,1,0,1, 1,1,1,3'b111, 1,1,1,1,1,1); check("R1");
    void'($urandom(32'h5eed_7a11));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rv;
      rv = $urandom();
      put((rv[0] | rv[1] | rv[2]), rv[4:3], rv[5], rv[6], rv[7] | rv[8], rv[9], rv[10],
          (rv[11] ? 3'b111 : rv[14:12]), rv[15], rv[16], rv[17] | rv[18], rv[19] | rv[20],
          rv[21] | rv[22], rv[23] | rv[24]);
      check($sformatf("%s/R2/R3", tag_of()));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule